// File: doc/BRIEF.md
# Dual Reference Frequency Range Monitor

This block checks two reference clocks, a primary and a secondary, at the same time against a local master clock. For each reference it raises a flag when the reference's frequency lies outside a fixed window around nominal. The window is ±17 ppm. Any error in the master clock adds directly to that limit: with a master that is off by 4.6 ppm, the effective window becomes ±21.6 ppm. Both references run at one common rate. A select input picks the rate: a frame-rate reference at 8 kHz, or a fast reference at 19.44 MHz. The fast reference is divided down to frame rate, so both rates share one measurement path.

Each channel has a small state machine with three states. WIN_ALIGN waits for the first frame strobe. WIN_GATE counts master cycles over a fixed number of frames, gives a verdict at the end of each window and then starts the next window. WIN_DEAD is entered while the reference shows no rising edges. The transitions are:
- align-to-gate, on a frame strobe;
- any-to-dead, when the channel's loss indication is high;
- dead-to-align, on the first cycle after the loss indication clears.

While a channel is in WIN_DEAD, its flag output does not give a steady level. It gives a one-cycle pulse from a shared free-running counter.

With the default parameters the master clock is 20 MHz. A window is 8192 frames, which is 20,480,000 nominal counts, and the tolerance is ±348 counts. Loss is declared after 4096 master cycles with no edge. The dead-reference pulse repeats every 25,200,000 cycles, which is about 1.26 s.

Top module: `ref_range_monitor`

## Requirements
- R1: After reset, both flags and both loss indications are low, and each channel waits for a frame strobe before it opens a window.
- R2: The two channels are fully independent. Each reference drives only its own flag and its own loss output.
- R3: In WIN_GATE, a channel counts master cycles between a window's opening strobe and the strobe FRAMES frames later. It gives its verdict at that closing strobe. The closing strobe also opens the next window, so windows run back to back.
- R4: A verdict sets the flag when the count is greater than NOMINAL+TOLERANCE or less than NOMINAL−TOLERANCE. It clears the flag otherwise, so a count exactly on either bound is in range.
- R5: Outside WIN_DEAD, the flag changes only on the cycle after a verdict. Between verdicts it holds its value.
- R6: With rate_sel=0, every synchronised rising edge of a reference is a frame strobe. With rate_sel=1, every DIV-th rising edge is a frame strobe.
- R7: A loss output rises once QUIET master cycles pass with no rising edge on its reference. A constant-low and a constant-high reference both count as having no edges. The loss output falls on the cycle after the next rising edge is detected.
- R8: While a channel is dead, its flag is a single-cycle high pulse, given once every PULSE_PERIOD master cycles. Both dead channels pulse in the same cycle.
- R9: When a reference recovers, its flag is low and stays low until the first verdict of a fresh window.
- R10: The window count saturates just above the upper bound, so a very slow reference that is still active is always judged out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pri | input | 1 | Primary reference, asynchronous to clk |
| ref_sec | input | 1 | Secondary reference, asynchronous to clk |
| rate_sel | input | 1 | 0: frame-rate reference; 1: fast reference divided by DIV |
| oor_pri | output | 1 | Primary out-of-range flag, or the dead pulse while the primary is lost |
| oor_sec | output | 1 | Secondary out-of-range flag, or the dead pulse while the secondary is lost |
| lost_pri | output | 1 | Primary reference shows no activity |
| lost_sec | output | 1 | Secondary reference shows no activity |

## Verification
The references are driven at periods that land exactly on the nominal count, exactly on each tolerance bound, and one step beyond each bound. This tells a correct inclusive comparison apart from an off-by-one or an inverted one. The fast mode is driven with a fast period that is in range only after division, and also with a frame-rate period that is in range only without division. Together these separate a working prescaler from a missing or mis-sized one. The references are also stopped low and held high, with the other channel kept alive, which tells the pulse behaviour, the loss timing and the independence of the channels apart from a shared or steady flag. A slow but active reference exercises count saturation.

// File: rtl/ref_range_pkg.sv
package ref_range_pkg;
    typedef enum logic [1:0] {
        WIN_ALIGN = 2'd0,
        WIN_GATE  = 2'd1,
        WIN_DEAD  = 2'd2
    } win_state_t;
endpackage

// File: rtl/rrm_edge_front.sv
module rrm_edge_front #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV         = 2430,
    parameter int QUIET       = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic rate_sel,
    output logic rise,
    output logic strobe,
    output logic lost
);
    localparam int DW = $clog2(DIV);
    localparam int QW = $clog2(QUIET + 1);
    localparam logic [DW-1:0] DIV_LAST  = DW'(DIV - 1);
    localparam logic [QW-1:0] QUIET_MAX = QW'(QUIET);

    logic [SYNC_STAGES:0] shift_q;
    logic [DW-1:0]        pre_q;
    logic [QW-1:0]        quiet_q;

    // synchroniser chain plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q[0] <= 1'b0;
        else        shift_q[0] <= ref_in;
    end

    for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shift_q[g] <= 1'b0;
            else        shift_q[g] <= shift_q[g-1];
        end
    end

    assign rise   = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
    assign strobe = rise & (~rate_sel | (pre_q == DIV_LAST));
    assign lost   = (quiet_q == QUIET_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (rise) begin
            if (!rate_sel || pre_q == DIV_LAST) pre_q <= '0;
            else                                pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  quiet_q <= '0;
        else if (rise)               quiet_q <= '0;
        else if (quiet_q != QUIET_MAX) quiet_q <= quiet_q + 1'b1;
    end
endmodule

// File: rtl/rrm_window_fsm.sv
module rrm_window_fsm
    import ref_range_pkg::*;
#(
    parameter int FRAMES    = 8192,
    parameter int NOMINAL   = 20480000,
    parameter int TOLERANCE = 348
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic lost,
    input  logic tick,
    output logic oor,
    output logic verdict,
    output logic dead
);
    localparam int CAP = NOMINAL + TOLERANCE + 1;
    localparam int CW  = $clog2(CAP + 1);
    localparam int FW  = $clog2(FRAMES);
    localparam logic [CW-1:0] CNT_CAP = CW'(CAP);
    localparam logic [CW-1:0] CNT_HI  = CW'(NOMINAL + TOLERANCE);
    localparam logic [CW-1:0] CNT_LO  = CW'(NOMINAL - TOLERANCE);
    localparam logic [FW-1:0] FR_LAST = FW'(FRAMES - 1);

    win_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [FW-1:0] fr_q;
    logic          flag_q;
    logic          last_frame;

    assign last_frame = (fr_q == FR_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WIN_ALIGN;
        else        st_q <= st_d;
    end

    // transitions: align-to-gate, any-to-dead, dead-to-align
    always_comb begin
        st_d = st_q;
        if (lost) begin
            st_d = WIN_DEAD;
        end else begin
            unique case (st_q)
                WIN_ALIGN: if (strobe) st_d = WIN_GATE;
                WIN_GATE:  st_d = WIN_GATE;
                WIN_DEAD:  st_d = WIN_ALIGN;
                default:   st_d = WIN_ALIGN;
            endcase
        end
    end

    // window counter and verdict register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fr_q   <= '0;
            flag_q <= 1'b0;
        end else if (lost) begin
            flag_q <= 1'b0;
        end else if (st_q == WIN_ALIGN && strobe) begin
            cnt_q <= CW'(1);
            fr_q  <= '0;
        end else if (st_q == WIN_GATE) begin
            if (strobe && last_frame) begin
                flag_q <= (cnt_q > CNT_HI) || (cnt_q < CNT_LO);
                cnt_q  <= CW'(1);
                fr_q   <= '0;
            end else begin
                if (strobe)            fr_q  <= fr_q + 1'b1;
                if (cnt_q != CNT_CAP)  cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        dead    = (st_q == WIN_DEAD);
        oor     = dead ? tick : flag_q;
        verdict = (st_q == WIN_GATE) && !lost && strobe && last_frame;
    end
endmodule

// File: rtl/rrm_pulse_gen.sv
module rrm_pulse_gen #(
    parameter int PERIOD = 25200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(PERIOD);
    localparam logic [PW-1:0] P_LAST = PW'(PERIOD - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cnt_q == P_LAST) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == P_LAST);
endmodule

// File: rtl/ref_range_monitor.sv
module ref_range_monitor #(
    parameter int DIV          = 2430,
    parameter int FRAMES       = 8192,
    parameter int NOMINAL      = 20480000,
    parameter int TOLERANCE    = 348,
    parameter int QUIET        = 4096,
    parameter int PULSE_PERIOD = 25200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pri,
    input  logic ref_sec,
    input  logic rate_sel,
    output logic oor_pri,
    output logic oor_sec,
    output logic lost_pri,
    output logic lost_sec
);
    localparam int NCH = 2;

    logic [NCH-1:0] ref_v, rise_v, strobe_v, lost_v, oor_v, verdict_v, dead_v;
    logic           tick;

    assign ref_v = {ref_sec, ref_pri};

    rrm_pulse_gen #(.PERIOD(PULSE_PERIOD)) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rrm_edge_front #(.SYNC_STAGES(2), .DIV(DIV), .QUIET(QUIET)) u_front (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_in  (ref_v[c]),
            .rate_sel(rate_sel),
            .rise    (rise_v[c]),
            .strobe  (strobe_v[c]),
            .lost    (lost_v[c])
        );

        rrm_window_fsm #(.FRAMES(FRAMES), .NOMINAL(NOMINAL), .TOLERANCE(TOLERANCE)) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (strobe_v[c]),
            .lost   (lost_v[c]),
            .tick   (tick),
            .oor    (oor_v[c]),
            .verdict(verdict_v[c]),
            .dead   (dead_v[c])
        );
    end

    assign oor_pri  = oor_v[0];
    assign oor_sec  = oor_v[1];
    assign lost_pri = lost_v[0];
    assign lost_sec = lost_v[1];
endmodule

// File: rtl/ref_range_monitor_chk.sv
module ref_range_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] oor,
    input logic [1:0] lost,
    input logic [1:0] rise,
    input logic [1:0] verdict,
    input logic [1:0] dead
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        // R8: a dead channel's pulse is exactly one cycle wide
        assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lost[c] && $past(lost[c]) && oor[c]) |=> !oor[c]);

        // R5: outside the dead state the flag moves only after a verdict
        assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!dead[c] && !$past(dead[c]) && !$past(verdict[c])) |-> $stable(oor[c]));

        // R7: loss clears only after a detected rising edge
        assert_lost_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lost[c]) |-> $past(rise[c]));
    end

    // R8: two dead channels pulse together from the shared counter
    assert_pulse_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost[0] && $past(lost[0]) && lost[1] && $past(lost[1])) |-> (oor[0] == oor[1]));
endmodule

bind ref_range_monitor ref_range_monitor_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .oor    (oor_v),
    .lost   (lost_v),
    .rise   (rise_v),
    .verdict(verdict_v),
    .dead   (dead_v)
);

// File: tb/ref_range_monitor_bench.sv
module ref_range_monitor_bench;
    localparam int DIV = 4;
    localparam int FR  = 2;
    localparam int NOM = 40;
    localparam int TOL = 2;
    localparam int QL  = 64;
    localparam int PP  = 300;
    localparam int CAP = NOM + TOL + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pri = 1'b0, ref_sec = 1'b0, rate_sel = 1'b0;
    logic oor_pri, oor_sec, lost_pri, lost_sec;

    int n_vec = 0, n_bad = 0, cyc = 0;
    int per [2] = '{0, 0};
    int lvl [2] = '{0, 0};
    int phs [2] = '{0, 0};

    // behavioural model state
    int m_s1 [2], m_s2 [2], m_s3 [2], m_q [2], m_pc [2], m_st [2], m_cnt [2], m_fc [2], m_fl [2];
    int m_tk;

    always #5 clk = ~clk;

    ref_range_monitor #(.DIV(DIV), .FRAMES(FR), .NOMINAL(NOM), .TOLERANCE(TOL),
                        .QUIET(QL), .PULSE_PERIOD(PP)) u_ref_range_monitor (
        .clk(clk), .rst_n(rst_n), .ref_pri(ref_pri), .ref_sec(ref_sec), .rate_sel(rate_sel),
        .oor_pri(oor_pri), .oor_sec(oor_sec), .lost_pri(lost_pri), .lost_sec(lost_sec)
    );

    // reference generators
    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            logic v;
            if (per[c] > 0) begin
                v = (phs[c] < per[c] / 2);
                phs[c] = (phs[c] + 1 >= per[c]) ? 0 : phs[c] + 1;
            end else begin
                v = (lvl[c] != 0);
            end
            if (c == 0) ref_pri = v; else ref_sec = v;
        end
    end

    // cycle model
    always @(posedge clk) begin
        int rs, ls, sb, rv;
        if (!rst_n) begin
            m_tk = 0;
            for (int c = 0; c < 2; c++) begin
                m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0; m_q[c] = 0; m_pc[c] = 0;
                m_st[c] = 0; m_cnt[c] = 0; m_fc[c] = 0; m_fl[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                rv = (c == 0) ? int'(ref_pri) : int'(ref_sec);
                rs = (m_s2[c] == 1 && m_s3[c] == 0) ? 1 : 0;
                ls = (m_q[c] == QL) ? 1 : 0;
                sb = (rs == 1 && (rate_sel == 1'b0 || m_pc[c] == DIV - 1)) ? 1 : 0;
                m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = rv;
                if (rs == 1) m_q[c] = 0; else if (m_q[c] != QL) m_q[c]++;
                if (rs == 1) m_pc[c] = (rate_sel && m_pc[c] != DIV - 1) ? m_pc[c] + 1 : 0;
                if (ls == 1) begin
                    m_st[c] = 2; m_fl[c] = 0;
                end else if (m_st[c] == 0) begin
                    if (sb == 1) begin m_st[c] = 1; m_cnt[c] = 1; m_fc[c] = 0; end
                end else if (m_st[c] == 1) begin
                    if (sb == 1 && m_fc[c] == FR - 1) begin
                        m_fl[c] = (m_cnt[c] > NOM + TOL || m_cnt[c] < NOM - TOL) ? 1 : 0;
                        m_cnt[c] = 1; m_fc[c] = 0;
                    end else begin
                        if (sb == 1) m_fc[c]++;
                        if (m_cnt[c] < CAP) m_cnt[c]++;
                    end
                end else begin
                    m_st[c] = 0;
                end
            end
            m_tk = (m_tk == PP - 1) ? 0 : m_tk + 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                logic eo, el, ao, al;
                eo = (m_st[c] == 2) ? (m_tk == PP - 1) : (m_fl[c] != 0);
                el = (m_q[c] == QL);
                ao = (c == 0) ? oor_pri : oor_sec;
                al = (c == 0) ? lost_pri : lost_sec;
                n_vec++;
                if (ao !== eo || al !== el) begin
                    n_bad++;
                    $display("FAIL R4/R7 model ch%0d cyc %0d: oor act %b exp %b, lost act %b exp %b",
                             c, cyc, ao, eo, al, el);
                end
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act %b exp %b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int hi_cnt, run, max_run, guard;
        wait_cyc(3);
        check(oor_pri, 1'b0, "R1 reset oor_pri");
        check(lost_sec, 1'b0, "R1 reset lost_sec");
        rst_n = 1'b1;
        per[0] = 20; per[1] = 22;
        wait_cyc(400);
        check(oor_pri, 1'b0, "R4 nominal primary in range");
        check(oor_sec, 1'b1, "R2 secondary out while primary in");
        hi_cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (oor_sec) hi_cnt++;
        end
        check(hi_cnt == 200, 1'b1, "R5 flag held across back-to-back windows");
        per[0] = 21; per[1] = 19;
        wait_cyc(400);
        check(oor_pri, 1'b0, "R4 upper bound inclusive");
        check(oor_sec, 1'b0, "R4 lower bound inclusive");
        per[0] = 22; per[1] = 18;
        wait_cyc(150);
        check(oor_pri, 1'b1, "R3 verdict within two windows, above bound");
        check(oor_sec, 1'b1, "R4 below bound");
        rate_sel = 1'b1; per[0] = 5; per[1] = 6;
        wait_cyc(400);
        check(oor_pri, 1'b0, "R6 fast ref divided to nominal");
        check(oor_sec, 1'b1, "R6 fast ref off nominal");
        per[0] = 20;
        wait_cyc(600);
        check(oor_pri, 1'b1, "R6 frame-rate ref in fast mode out of range");
        rate_sel = 1'b0; per[0] = 60; per[1] = 20;
        wait_cyc(500);
        check(lost_pri, 1'b0, "R10 slow ref still active");
        check(oor_pri, 1'b1, "R10 saturated count out of range");
        per[0] = 0; lvl[0] = 0;
        wait_cyc(100);
        check(lost_pri, 1'b1, "R7 stuck-low ref lost");
        check(lost_sec, 1'b0, "R2 secondary unaffected");
        hi_cnt = 0; run = 0; max_run = 0;
        for (int i = 0; i < 2 * PP; i++) begin
            @(negedge clk);
            if (oor_pri) begin hi_cnt++; run++; end else run = 0;
            if (run > max_run) max_run = run;
        end
        check(hi_cnt == 2, 1'b1, "R8 two pulses in two periods");
        check(max_run == 1, 1'b1, "R8 pulse one cycle wide");
        check(oor_sec, 1'b0, "R2 secondary still in range");
        per[1] = 0; lvl[1] = 1;
        wait_cyc(100);
        check(lost_sec, 1'b1, "R7 stuck-high ref lost");
        per[0] = 20;
        guard = 0;
        while (lost_pri && guard < 200) begin @(negedge clk); guard++; end
        wait_cyc(1);
        check(oor_pri, 1'b0, "R9 flag low on recovery");
        check(lost_pri, 1'b0, "R7 loss cleared after edge");
        wait_cyc(300);
        check(oor_pri, 1'b0, "R9 fresh verdict in range");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule